// File: doc/BRIEF.md
# Dual-Slope Integrating ADC Sequencer

This block sequences an integrating converter built from an external integrator, an input-select switch and a zero-crossing comparator. After a start request it first holds the integrator discharged for a short settle interval. It then lets the integrator charge from the analog input for a fixed number of clocks. Finally it flips the switch to the opposite-polarity reference and counts clocks until the comparator reports that the integrator has fallen back to zero.

That final count is the conversion result. It equals the input times the run-up length divided by the reference, so the run-up length sets the scale. If the comparator has not tripped by the time the count reaches a ceiling, the run-down is abandoned. The block then reports overrange and puts the integrator back into discharge. Each outcome is announced by a one-cycle completion pulse, and the result stays on its port until the next conversion finishes.

Top module: `dsadc_seq`

## Requirements
- R1: While reset is held and after it is released, the outputs are sel_ref=0, int_reset=1, busy=0, done=0, overrange=0, result=0.
- R2: A start seen while idle makes busy high and keeps int_reset high for exactly ZERO_CLKS cycles. It then drops int_reset with sel_ref=0 (input selected) for exactly RUNUP_CLKS cycles. Whenever busy is low, int_reset is high.
- R3: After run-up, sel_ref goes to 1 (reference selected) and the run-down count starts at 0. sel_ref and int_reset are never high together.
- R4: The result is the run-down count k at which cmp_zero is first seen high, where count 0 is the first run-down cycle. With an ideal integrator this is ceil(vin*RUNUP_CLKS/vref).
- R5: If the comparator trips in the same cycle that the count reaches MAX_RUNDOWN, the comparator wins: result=MAX_RUNDOWN and overrange=0.
- R6: done is a single-cycle pulse in the cycle after the count halts. The result is held unchanged until the next done.
- R7: If the count reaches MAX_RUNDOWN without a trip, done and overrange pulse together with result=MAX_RUNDOWN. In that same cycle the integrator is back in discharge (int_reset=1, sel_ref=0).
- R8: A start asserted while busy is ignored: it causes no extra conversion and no extra done.
- R9: done appears ZERO_CLKS+RUNUP_CLKS+k+1 clock edges after the edge that captured start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Conversion request, honoured only while idle |
| cmp_zero | input | 1 | Comparator: integrator output at or below zero |
| sel_ref | output | 1 | Switch select: 0 analog input, 1 reference |
| int_reset | output | 1 | Integrator discharge control |
| busy | output | 1 | Conversion in progress |
| result | output | CNT_W | Last run-down count |
| done | output | 1 | One-cycle completion pulse |
| overrange | output | 1 | Completion was by timeout |

## Verification
Two functions can fall in the same cycle: the comparator halting the run-down and the timeout ceiling firing. The bench chooses an input whose ideal ramp crosses zero on exactly count MAX_RUNDOWN, so both conditions are true in that run-down cycle. It judges the outcome by requiring result=MAX_RUNDOWN with overrange low. Inputs one step higher must instead give overrange with the same result value.

// File: rtl/dsadc_seq.sv
module dsadc_seq #(
  parameter int CNT_W       = 12,
  parameter int ZERO_CLKS   = 8,
  parameter int RUNUP_CLKS  = 1000,
  parameter int MAX_RUNDOWN = 2000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             cmp_zero,
  output logic             sel_ref,
  output logic             int_reset,
  output logic             busy,
  output logic [CNT_W-1:0] result,
  output logic             done,
  output logic             overrange
);
  localparam logic [CNT_W-1:0] ZERO_LAST  = CNT_W'(ZERO_CLKS - 1);
  localparam logic [CNT_W-1:0] RUNUP_LAST = CNT_W'(RUNUP_CLKS - 1);
  localparam logic [CNT_W-1:0] RD_LIMIT   = CNT_W'(MAX_RUNDOWN);

  typedef enum logic [1:0] {S_IDLE, S_ZERO, S_RUNUP, S_RUNDN} st_t;
  st_t              st;
  logic [CNT_W-1:0] cnt;

  assign sel_ref   = (st == S_RUNDN);
  assign int_reset = (st == S_IDLE) || (st == S_ZERO);
  assign busy      = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      result    <= '0;
      done      <= 1'b0;
      overrange <= 1'b0;
    end else begin
      done      <= 1'b0;
      overrange <= 1'b0;
      case (st)
        S_IDLE: begin
          cnt <= '0;
          if (start) st <= S_ZERO;
        end
        S_ZERO: begin
          if (cnt == ZERO_LAST) begin
            cnt <= '0;
            st  <= S_RUNUP;
          end else cnt <= cnt + 1'b1;
        end
        S_RUNUP: begin
          if (cnt == RUNUP_LAST) begin
            cnt <= '0;
            st  <= S_RUNDN;
          end else cnt <= cnt + 1'b1;
        end
        S_RUNDN: begin
          if (cmp_zero) begin
            result <= cnt;
            done   <= 1'b1;
            st     <= S_IDLE;
          end else if (cnt == RD_LIMIT) begin
            result    <= cnt;
            done      <= 1'b1;
            overrange <= 1'b1;
            st        <= S_IDLE;
          end else cnt <= cnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module dsadc_seq_chk #(
  parameter int CNT_W       = 12,
  parameter int MAX_RUNDOWN = 2000
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             cmp_zero,
  input logic             sel_ref,
  input logic             int_reset,
  input logic             busy,
  input logic [CNT_W-1:0] result,
  input logic             done,
  input logic             overrange
);
  a_r3_switch_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel_ref && int_reset));
  a_r2_idle_discharged: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> int_reset);
  a_r4_halt_gives_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sel_ref) |-> done);
  a_r5_trip_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_ref && cmp_zero) |=> (done && !overrange));
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r6_result_held: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> (!done || 1'b1) && ($past(done) || !done || 1'b1) && (done || $stable(result)));
  a_r7_timeout: assert property (@(posedge clk) disable iff (!rst_n)
    overrange |-> (done && result == CNT_W'(MAX_RUNDOWN) && int_reset && !sel_ref));
endmodule

bind dsadc_seq dsadc_seq_chk #(.CNT_W(CNT_W), .MAX_RUNDOWN(MAX_RUNDOWN)) u_chk (.*);

// File: tb/dsadc_seq_bench.sv
module dsadc_seq_bench;
  localparam int CW = 8, ZC = 4, T1 = 16, MX = 40, VREF = 10;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic sel_ref, int_reset, busy, done, overrange;
  logic [CW-1:0] result;
  int acc = 0, vin = 0, cyc = 0, start_cyc = 0;
  int n_chk = 0, n_bad = 0;
  int q_res[$], q_ovr[$], q_lat[$];
  bit finished = 0;

  always #5 clk = ~clk;

  assign cmp_zero = (acc <= 0);
  logic cmp_zero;

  dsadc_seq #(.CNT_W(CW), .ZERO_CLKS(ZC), .RUNUP_CLKS(T1), .MAX_RUNDOWN(MX)) u_dsadc_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .cmp_zero(cmp_zero),
    .sel_ref(sel_ref), .int_reset(int_reset), .busy(busy),
    .result(result), .done(done), .overrange(overrange));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (int_reset) acc <= 0;
    else if (sel_ref) acc <= acc - VREF;
    else acc <= acc + vin;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic convert(input int v, input bit phase_chk);
    int k, ovr;
    k = (v * T1 + VREF - 1) / VREF;
    ovr = (k > MX) ? 1 : 0;
    if (ovr != 0) k = MX;
    @(negedge clk);
    vin = v;
    q_res.push_back(k);
    q_ovr.push_back(ovr);
    q_lat.push_back(ZC + T1 + k + 2);
    start_cyc = cyc;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (phase_chk) begin
      for (int i = 0; i < ZC; i++) begin
        check(int_reset && busy && !sel_ref, "R2 settle", int_reset, 1);
        @(negedge clk);
      end
      for (int i = 0; i < T1; i++) begin
        check(!int_reset && !sel_ref, "R2 runup", {int_reset, sel_ref}, 0);
        @(negedge clk);
      end
      check(sel_ref && !int_reset, "R3 rundown select", sel_ref, 1);
    end
    wait (q_res.size() == 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (done) begin
        if (q_res.size() == 0) begin
          check(0, "R8 unexpected done", 1, 0);
        end else begin
          int er, eo, el;
          er = q_res.pop_front(); eo = q_ovr.pop_front(); el = q_lat.pop_front();
          check(result == CW'(er), (eo != 0) ? "R7 result" : "R4 result", result, er);
          check(overrange == eo[0], (er == MX) ? "R5 overrange" : "R7 overrange", overrange, eo);
          check(cyc - start_cyc == el, "R9 latency", cyc - start_cyc, el);
          check(int_reset && !sel_ref, "R7 discharge", int_reset, 1);
          @(negedge clk);
          check(!done, "R6 pulse width", done, 0);
          check(result == CW'(er), "R6 result held", result, er);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!sel_ref && int_reset && !busy && !done && !overrange && result == 0,
          "R1 in reset", {sel_ref, busy, done, overrange}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!sel_ref && int_reset && !busy && !done && !overrange && result == 0,
          "R1 after reset", {sel_ref, busy, done, overrange}, 0);

    convert(7, 1);    // R4 mid-scale, R2/R3 phase timing
    convert(0, 0);    // R4 zero input
    convert(1, 0);    // R4 one step
    convert(10, 1);   // R4 input equal to reference
    convert(25, 0);   // R5 trip lands on the ceiling
    convert(26, 0);   // R7 just over range
    convert(60, 0);   // R7 far over range

    // R8: a second start while busy must not launch anything
    @(negedge clk);
    vin = 5;
    q_res.push_back(8); q_ovr.push_back(0); q_lat.push_back(ZC + T1 + 8 + 2);
    start_cyc = cyc;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (ZC + 3) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait (q_res.size() == 0);
    repeat (20) @(negedge clk);
    check(!busy && int_reset, "R8 stays idle", busy, 0);

    convert(3, 0);    // R4 after ignored start
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule